// File: doc/BRIEF.md
# SPI EEPROM Configuration Copy Engine

This engine copies a range of 16-bit internal memory words out to an external SPI serial EEPROM, so that they can be restored from it later. Each word is sent as two bytes, high byte first, to EEPROM byte address 2 × word address. The writes are grouped into page bursts that never cross a 128-byte page, which is 64 words. Each burst is preceded by a write-enable frame. After each burst the engine keeps reading the EEPROM status until the write-in-progress bit reads 0.

The host pulses `start_i` and picks the copy length with `size_sel_i`. The small size copies the lower 1K words, the amount a 2K-byte part holds. The full size copies all 32K words, the amount a 64K-byte part holds. The serial clock is the system clock divided by 2 × `HALF_DIV`, which with the default setting gives about 8.3 MHz from 200 MHz. `mode3_i` selects the idle level of SCK. In both SPI modes 1 and 3, data is driven on the first edge of each bit and sampled on the second edge. Memory reads have one cycle of latency.

Top module: `eecopy_engine`

## Requirements
- R1: While reset is asserted, and whenever the engine is not busy, cs_no is 1, busy_o is 0 and no SPI frame is open. Directly after reset, done_o is also 0.
- R2: SCK rests at the level of mode3_i (0 for mode 1, 1 for mode 3) whenever cs_no is 1. MOSI changes only on the leading edge of a bit, which is the edge away from the resting level. MISO is sampled on the trailing edge. Bytes are sent MSB first.
- R3: Every page-write frame (command 0x02) is preceded by a write-enable frame (command 0x06) in its own chip-select period.
- R4: A page-write frame carries 0x02, then a 16-bit byte address (high byte first) equal to 2 × the first word address, then the data. Each word is sent high byte then low byte, with its value read from mem_addr_o.
- R5: No page-write frame crosses a 128-byte EEPROM page boundary. Each burst therefore carries at most 64 words.
- R6: After each page-write frame, the engine sends read-status frames (0x05 followed by one read byte) until bit 0 of the returned status is 0. It sends no other command while that bit is 1.
- R7: With size_sel_i = 0 exactly SMALL_WORDS words are copied, starting at word 0. With size_sel_i = 1 exactly FULL_WORDS words are copied.
- R8: busy_o rises on the cycle after an accepted start. done_o rises in the cycle where busy_o falls and stays high until the next accepted start. busy_o and done_o are never high together. A start while busy is ignored and does not restart the copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse from host |
| size_sel_i | input | 1 | 0: small copy length, 1: full copy length |
| mode3_i | input | 1 | SCK idle level (0: SPI mode 1, 1: SPI mode 3) |
| busy_o | output | 1 | Copy in progress |
| done_o | output | 1 | Last copy finished |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 15 | Memory word address |
| mem_rdata_i | input | 16 | Memory read data, valid one cycle after strobe |
| sck_o | output | 1 | SPI serial clock |
| mosi_o | output | 1 | SPI data to EEPROM |
| miso_i | input | 1 | SPI data from EEPROM |
| cs_no | output | 1 | SPI chip select, active low |

## Verification
Two events can land in the same cycle: a host start arriving while a copy runs, and the engine's own transitions between bursts. The bench pulses start in the middle of every copy and checks that busy stays high. After the copy it counts the bytes the EEPROM model received, which must be exactly twice the word count, so a restart would show up as extra bytes. The status poll can also report busy in the same frame that follows a burst. The model holds the write-in-progress bit for a programmed number of polls, and the bench checks both the poll total and that no write-enable or write frame arrives while that bit is set.

// File: rtl/eecopy_pkg.sv
package eecopy_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_WREN, S_WREN_GAP, S_WR_CMD, S_ADR_H, S_ADR_L,
    S_RD, S_DAT_H, S_DAT_L, S_WR_GAP, S_POLL_CMD, S_POLL_RD, S_POLL_GAP
  } seq_state_e;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_RDSR  = 8'h05;
endpackage

// File: rtl/eecopy_spi_shift.sv
module eecopy_spi_shift #(
  parameter int HALF_DIV = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cpol_i,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       done_o,
  output logic [7:0] rx_o,
  output logic       sck_o,
  output logic       mosi_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(HALF_DIV - 1);

  logic          run_q, act_q, mosi_q, done_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]    bit_q;
  logic [7:0]    sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      act_q  <= 1'b0;
      mosi_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !run_q) begin
        run_q  <= 1'b1;
        act_q  <= 1'b1;           // leading edge, drive bit 7
        mosi_q <= tx_i[7];
        sh_q   <= tx_i;
        bit_q  <= '0;
        cnt_q  <= CNT_LOAD;
      end else if (run_q) begin
        if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
        end else if (act_q) begin
          act_q <= 1'b0;          // trailing edge, sample
          sh_q  <= {sh_q[6:0], miso_i};
          cnt_q <= CNT_LOAD;
        end else if (bit_q == 3'd7) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end else begin
          bit_q  <= bit_q + 1'b1;
          act_q  <= 1'b1;
          mosi_q <= sh_q[7];
          cnt_q  <= CNT_LOAD;
        end
      end
    end
  end

  assign done_o = done_q;
  assign rx_o   = sh_q;
  assign sck_o  = cpol_i ^ act_q;
  assign mosi_o = mosi_q;
endmodule

// File: rtl/eecopy_seq.sv
module eecopy_seq
  import eecopy_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int PAGE_BYTES  = 128,
  parameter int SMALL_WORDS = 1024,
  parameter int FULL_WORDS  = 32768,
  parameter int GAP_CYC     = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              size_sel_i,
  input  logic              sh_done_i,
  input  logic [7:0]        rx_i,
  output logic              sh_start_o,
  output logic [7:0]        tx_o,
  output logic              cs_no,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [15:0]       mem_rdata_i,
  output logic              busy_o,
  output logic              done_o
);
  localparam int PAGE_WORDS = PAGE_BYTES / 2;
  localparam int PWL        = $clog2(PAGE_WORDS);
  localparam int GW         = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam logic [ADDR_W:0] SMALL_N = (ADDR_W+1)'(SMALL_WORDS);
  localparam logic [ADDR_W:0] FULL_N  = (ADDR_W+1)'(FULL_WORDS);

  seq_state_e      st_q;
  logic            pend_q, size_q, done_q, wip_q;
  logic [ADDR_W:0] widx_q;
  logic [15:0]     word_q;
  logic [GW-1:0]   gap_q;
  logic [15:0]     byte_addr;
  logic [ADDR_W:0] widx_nxt, total;
  logic            byte_st, gap_end, page_last;

  assign byte_addr = 16'({widx_q[ADDR_W-1:0], 1'b0});
  assign widx_nxt  = widx_q + 1'b1;
  assign total     = size_q ? FULL_N : SMALL_N;
  assign page_last = &widx_q[PWL-1:0];
  assign gap_end   = (gap_q == GW'(GAP_CYC - 1));

  always_comb begin
    byte_st = 1'b1;
    tx_o    = 8'h00;
    unique case (st_q)
      S_WREN:     tx_o = OP_WREN;
      S_WR_CMD:   tx_o = OP_WRITE;
      S_ADR_H:    tx_o = byte_addr[15:8];
      S_ADR_L:    tx_o = byte_addr[7:0];
      S_DAT_H:    tx_o = mem_rdata_i[15:8];
      S_DAT_L:    tx_o = word_q[7:0];
      S_POLL_CMD: tx_o = OP_RDSR;
      S_POLL_RD:  tx_o = 8'h00;
      default:    byte_st = 1'b0;
    endcase
  end

  assign sh_start_o = byte_st && !pend_q;
  assign cs_no      = !(byte_st || st_q == S_RD);
  assign mem_rd_o   = (st_q == S_RD);
  assign mem_addr_o = widx_q[ADDR_W-1:0];
  assign busy_o     = (st_q != S_IDLE);
  assign done_o     = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      pend_q <= 1'b0;
      size_q <= 1'b0;
      done_q <= 1'b0;
      wip_q  <= 1'b0;
      widx_q <= '0;
      word_q <= '0;
      gap_q  <= '0;
    end else begin
      if (byte_st) begin
        if (!pend_q) begin
          pend_q <= 1'b1;
          if (st_q == S_DAT_H) word_q <= mem_rdata_i;
        end else if (sh_done_i) begin
          pend_q <= 1'b0;
        end
      end
      gap_q <= '0;
      unique case (st_q)
        S_IDLE: if (start_i) begin
          st_q   <= S_WREN;
          size_q <= size_sel_i;
          widx_q <= '0;
          done_q <= 1'b0;
        end
        S_WREN:     if (pend_q && sh_done_i) st_q <= S_WREN_GAP;
        S_WREN_GAP: if (gap_end) st_q <= S_WR_CMD; else gap_q <= gap_q + 1'b1;
        S_WR_CMD:   if (pend_q && sh_done_i) st_q <= S_ADR_H;
        S_ADR_H:    if (pend_q && sh_done_i) st_q <= S_ADR_L;
        S_ADR_L:    if (pend_q && sh_done_i) st_q <= S_RD;
        S_RD:       st_q <= S_DAT_H;
        S_DAT_H:    if (pend_q && sh_done_i) st_q <= S_DAT_L;
        S_DAT_L: if (pend_q && sh_done_i) begin
          widx_q <= widx_nxt;
          st_q   <= (widx_nxt == total || page_last) ? S_WR_GAP : S_RD;
        end
        S_WR_GAP:   if (gap_end) st_q <= S_POLL_CMD; else gap_q <= gap_q + 1'b1;
        S_POLL_CMD: if (pend_q && sh_done_i) st_q <= S_POLL_RD;
        S_POLL_RD: if (pend_q && sh_done_i) begin
          wip_q <= rx_i[0];
          st_q  <= S_POLL_GAP;
        end
        S_POLL_GAP: if (!gap_end) begin
          gap_q <= gap_q + 1'b1;
        end else if (wip_q) begin
          st_q <= S_POLL_CMD;
        end else if (widx_q == total) begin
          st_q   <= S_IDLE;
          done_q <= 1'b1;
        end else begin
          st_q <= S_WREN;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eecopy_engine.sv
module eecopy_engine #(
  parameter int ADDR_W      = 15,
  parameter int PAGE_BYTES  = 128,
  parameter int SMALL_WORDS = 1024,
  parameter int FULL_WORDS  = 32768,
  parameter int HALF_DIV    = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              size_sel_i,
  input  logic              mode3_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [15:0]       mem_rdata_i,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              cs_no
);
  logic       sh_start, sh_done;
  logic [7:0] sh_tx, sh_rx;

  eecopy_seq #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .SMALL_WORDS(SMALL_WORDS),
    .FULL_WORDS(FULL_WORDS), .GAP_CYC(HALF_DIV)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .size_sel_i(size_sel_i),
    .sh_done_i(sh_done), .rx_i(sh_rx), .sh_start_o(sh_start), .tx_o(sh_tx),
    .cs_no(cs_no), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
    .mem_rdata_i(mem_rdata_i), .busy_o(busy_o), .done_o(done_o)
  );

  eecopy_spi_shift #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .cpol_i(mode3_i), .start_i(sh_start),
    .tx_i(sh_tx), .miso_i(miso_i), .done_o(sh_done), .rx_o(sh_rx),
    .sck_o(sck_o), .mosi_o(mosi_o)
  );
endmodule

// File: rtl/eecopy_checker.sv
module eecopy_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic mode3_i,
  input logic busy_o,
  input logic done_o,
  input logic mem_rd_o,
  input logic sck_o,
  input logic mosi_o,
  input logic cs_no
);
  p_cs_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cs_no);
  p_sck_rest_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> (sck_o == mode3_i));
  p_mosi_lead_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mosi_o) |-> (sck_o != mode3_i));
  p_rd_in_frame_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> !cs_no);
  p_busy_done_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  p_done_on_finish_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $fell(busy_o));
  p_start_accept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
endmodule

bind eecopy_engine eecopy_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode3_i(mode3_i),
  .busy_o(busy_o), .done_o(done_o), .mem_rd_o(mem_rd_o), .sck_o(sck_o),
  .mosi_o(mosi_o), .cs_no(cs_no)
);

// File: tb/eecopy_engine_bench.sv
module eecopy_engine_bench;
  localparam int AW = 15;
  localparam int SMALL = 80;
  localparam int FULL = 160;
  localparam int HALF = 2;
  // {mode3, size_sel, busy polls per page}
  localparam logic [5:0] VEC [4] = '{
    {1'b0, 1'b0, 4'd0}, {1'b1, 1'b0, 4'd2}, {1'b0, 1'b1, 4'd1}, {1'b1, 1'b1, 4'd3}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, size_sel = 1'b0, mode3 = 1'b0;
  logic busy, done, mem_rd, sck, mosi, miso = 1'b0, cs_n;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_rdata = '0;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  eecopy_engine #(.ADDR_W(AW), .SMALL_WORDS(SMALL), .FULL_WORDS(FULL),
                  .HALF_DIV(HALF)) u_eecopy_engine (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .size_sel_i(size_sel),
    .mode3_i(mode3), .busy_o(busy), .done_o(done), .mem_rd_o(mem_rd),
    .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata), .sck_o(sck),
    .mosi_o(mosi), .miso_i(miso), .cs_no(cs_n)
  );

  function automatic logic [15:0] pat(int a);
    return 16'(a * 40503) ^ 16'hA5C3;
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= pat(int'(mem_addr));

  // EEPROM model
  logic [7:0] ee [1024];
  int nbytes, pages, polls, err_tim, err_proto, err_page, wip_left, cur_polls;
  logic wel, prev_sck, prev_cs, prev_mosi;
  int bitc, bytec;
  logic [7:0] sh, cmd, ahi;
  logic [15:0] base;

  task automatic model_clear();
    for (int i = 0; i < 1024; i++) ee[i] = 8'h00;
    nbytes = 0; pages = 0; polls = 0; err_tim = 0; err_proto = 0; err_page = 0;
    wip_left = 0; wel = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_cs && !cs_n) begin bitc = 0; bytec = 0; cmd = 8'h00; sh = 8'h00; end
      if (!cs_n) begin
        automatic logic lead  = (sck != mode3) && (prev_sck == mode3);
        automatic logic trail = (sck == mode3) && (prev_sck != mode3);
        if (mosi != prev_mosi && !lead) err_tim++;
        if (lead) miso <= (cmd == 8'h05 && bytec == 1 && bitc == 7) ? (wip_left > 0) : 1'b0;
        if (trail) begin
          sh = {sh[6:0], mosi};
          bitc++;
          if (bitc == 8) begin
            bitc = 0;
            if (bytec == 0) begin
              cmd = sh;
              if (wip_left > 0 && sh != 8'h05) err_proto++;
              if (sh == 8'h02 && !wel) err_proto++;
            end else if (bytec == 1) ahi = sh;
            else if (bytec == 2) base = {ahi, sh};
            else if (cmd == 8'h02) begin
              automatic logic [15:0] a = base + 16'(bytec - 3);
              if (a[15:7] != base[15:7]) err_page++;
              if (a < 16'd1024) ee[a] = sh;
              nbytes++;
            end
            bytec++;
          end
        end
      end
      if (!prev_cs && cs_n) begin
        if (cmd == 8'h06 && bytec == 1) wel = 1'b1;
        if (cmd == 8'h02 && bytec >= 3) begin wel = 1'b0; wip_left = cur_polls; pages++; end
        if (cmd == 8'h05 && bytec == 2) begin polls++; if (wip_left > 0) wip_left--; end
      end
    end
    prev_sck = sck; prev_cs = cs_n; prev_mosi = mosi;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_idle(output logic timeout);
    timeout = 1'b0;
    for (int n = 0; n < 60000; n++) begin
      @(negedge clk);
      if (!busy) return;
    end
    timeout = 1'b1;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  initial begin
    logic to;
    model_clear();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(cs_n == 1'b1, "R1 cs_n in reset", int'(cs_n), 1);
    chk(busy == 1'b0 && done == 1'b0, "R1 busy/done in reset", int'({busy, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sck == mode3, "R2 sck rest mode1", int'(sck), int'(mode3));

    foreach (VEC[v]) begin
      automatic int words = VEC[v][4] ? FULL : SMALL;
      automatic int npg = (words + 63) / 64;
      automatic int bad = 0;
      mode3 = VEC[v][5]; size_sel = VEC[v][4]; cur_polls = int'(VEC[v][3:0]);
      model_clear();
      @(negedge clk);
      chk(sck == mode3, "R2 sck idle level", int'(sck), int'(mode3));
      pulse_start();
      chk(busy == 1'b1 && done == 1'b0, "R8 busy after start", int'({busy, done}), 2);
      repeat (100) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
      chk(busy == 1'b1, "R8 start while busy", int'(busy), 1);
      wait_idle(to);
      chk(!to, "R8 watchdog", int'(to), 0);
      if (to) break;
      chk(done == 1'b1, "R8 done after copy", int'(done), 1);
      chk(nbytes == 2 * words, "R7 bytes copied", nbytes, 2 * words);
      for (int i = 0; i < words; i++) begin
        automatic logic [15:0] p = pat(i);
        if (ee[2*i] != p[15:8] || ee[2*i+1] != p[7:0]) bad++;
      end
      chk(bad == 0, "R4 word content and order", bad, 0);
      chk(pages == npg && err_page == 0, "R5 page bursts", pages * 100 + err_page, npg * 100);
      chk(polls == npg * (cur_polls + 1), "R6 status polls", polls, npg * (cur_polls + 1));
      chk(err_proto == 0, "R3 R6 command order", err_proto, 0);
      chk(err_tim == 0, "R2 mosi on leading edge", err_tim, 0);
    end

    // R1: reset in mid copy
    mode3 = 1'b1; size_sel = 1'b1; cur_polls = 0; model_clear();
    pulse_start();
    repeat (200) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(cs_n == 1'b1 && busy == 1'b0 && done == 1'b0, "R1 reset mid copy",
        int'({cs_n, busy, done}), 4);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && sck == mode3, "R1 idle after reset", int'({busy, sck}), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule